// File: doc/BRIEF.md
# Streaming DAC Code Gain and Offset Corrector

This block sits in front of a 16-bit digital-to-analog converter and rewrites every requested code so that a converter with measured gain and offset errors behaves like an ideal one. Software loads two coefficients once, usually after a factory measurement. A gain word scales each code by (gain + 1) / 2^16. An offset word, centred at mid-scale, then shifts the scaled code by a signed number of LSBs. The corrected result is saturated to the legal code range and sent out with a valid strobe.

The gain word starts at its all-ones value, which is unity. To reduce the span, software subtracts from that word the number of LSBs by which the span is too large. For example, 326 LSB for a 50 mV excess on a 10 V range. The offset word starts at mid-scale, which adds nothing. To correct an offset, software adds or subtracts the number of LSBs of offset, such as 196 LSB for 30 mV. After that, the host streams ideal codes and never does the reciprocal multiply or the offset add itself.

Data moves through two register stages, a scaling multiply followed by an offset add with clamp. A valid flag travels with each word, and gaps in the input stream come out as gaps in the output stream.

Top module: `dac_lincal`

## Requirements
- R1: After reset, out_valid is 0 and out_code is 0.
- R2: With the reset coefficients (gain 0xFFFF, offset 0x8000), every input code 0 to 0xFFFF comes out unchanged.
- R3: The scaled value is floor(in_code × (gain + 1) / 65536).
- R4: The output is the scaled value plus (offset − 0x8000), where the offset word is treated as unsigned.
- R5: A sum above 0xFFFF comes out as 0xFFFF.
- R6: A sum below 0 comes out as 0.
- R7: A word accepted with in_valid=1 at clock edge k appears with out_valid=1 after edge k+1 (two cycles of latency). Exactly one output word is produced for each input word, in order, and a cycle with in_valid=0 produces a cycle with out_valid=0.
- R8: A coefficient write is made with cfg_we=1. cfg_sel=0 selects the gain word and cfg_sel=1 selects the offset word. The write applies to the first input word accepted at a later clock edge. A word accepted at the same edge as the write still uses the old gain and the old offset.
- R9: Reset returns the gain word to 0xFFFF and the offset word to 0x8000, whatever was written before it.
- R10: While out_valid is 0, out_code holds its last value, even if in_code changes while in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 1 | Coefficient select: 0 gain, 1 offset |
| cfg_data | input | 16 | Coefficient write value |
| in_valid | input | 1 | Input code qualifier |
| in_code | input | 16 | Ideal requested code |
| out_valid | output | 1 | Corrected code qualifier |
| out_code | output | 16 | Corrected, saturated code for the converter |

## Verification
A corrupted gain or offset register shows up as a wrong out_code two edges after the next accepted word. A coefficient captured at the wrong edge shows as an error only on the word that shares its edge with a write, so that boundary is driven on purpose for both coefficients. A valid flag that is lost, duplicated or late shows up at once: the bench pairs every output with the cycle in which it is due. A clamp fault shows only at the extremes, so sweeps pin the sum above full scale and below zero. The default configuration is swept exhaustively, and it must return each code unchanged.

// File: rtl/dac_lincal_pkg.sv
package dac_lincal_pkg;
   typedef enum logic {
      COEF_GAIN   = 1'b0,
      COEF_OFFSET = 1'b1
   } coef_sel_e;
endpackage

// File: rtl/dac_lincal_coef.sv
module dac_lincal_coef
   import dac_lincal_pkg::*;
#(
   parameter int GAIN_W = 16,
   parameter int CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CODE_W-1:0] cfg_data,
   output logic [GAIN_W-1:0] gain_q,
   output logic [CODE_W-1:0] ofs_q
);
   localparam logic [GAIN_W-1:0] GAIN_UNITY = {GAIN_W{1'b1}};
   localparam logic [CODE_W-1:0] OFS_CENTRE = CODE_W'(1) << (CODE_W-1);

   coef_sel_e sel;
   assign sel = coef_sel_e'(cfg_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_q <= GAIN_UNITY;
         ofs_q  <= OFS_CENTRE;
      end else if (cfg_we) begin
         if (sel == COEF_GAIN) gain_q <= GAIN_W'(cfg_data);
         else                  ofs_q  <= cfg_data;
      end
   end

   AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(gain_q) && $stable(ofs_q))); // R8
   AST_GAIN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel) |=> $stable(gain_q)); // R8
   AST_OFS_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_sel) |=> $stable(ofs_q)); // R8
endmodule

// File: rtl/dac_lincal_scale.sv
module dac_lincal_scale #(
   parameter int CODE_W    = 16,
   parameter int GAIN_W    = 16,
   parameter bit SHIFT_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_code,
   input  logic [GAIN_W-1:0] gain,
   input  logic [CODE_W-1:0] ofs,
   output logic              s_valid,
   output logic [CODE_W-1:0] s_scaled,
   output logic [CODE_W-1:0] s_ofs
);
   localparam int FACT_W = GAIN_W + 1;
   localparam int PROD_W = CODE_W + FACT_W;

   logic [FACT_W-1:0] factor;
   logic [PROD_W-1:0] product;

   assign factor = {1'b0, gain} + FACT_W'(1);

   generate
      if (SHIFT_ADD) begin : g_shift_add
         logic [PROD_W-1:0] partial [CODE_W];
         for (genvar i = 0; i < CODE_W; i++) begin : g_pp
            assign partial[i] = in_code[i] ? (PROD_W'(factor) << i) : '0;
         end
         always_comb begin
            product = '0;
            for (int j = 0; j < CODE_W; j++) product = product + partial[j];
         end
      end else begin : g_direct
         assign product = PROD_W'(in_code) * PROD_W'(factor);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_valid  <= 1'b0;
         s_scaled <= '0;
         s_ofs    <= '0;
      end else begin
         s_valid <= in_valid;
         if (in_valid) begin
            s_scaled <= product[GAIN_W +: CODE_W];
            s_ofs    <= ofs;
         end
      end
   end

   AST_SCALE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s_valid); // R7
   AST_SCALE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!s_valid && $stable(s_scaled) && $stable(s_ofs))); // R10
   AST_SCALE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (s_scaled <= $past(in_code))); // R3
endmodule

// File: rtl/dac_lincal_shift.sv
module dac_lincal_shift #(
   parameter int CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic [CODE_W-1:0] s_scaled,
   input  logic [CODE_W-1:0] s_ofs,
   output logic              out_valid,
   output logic [CODE_W-1:0] out_code
);
   localparam int SUM_W = CODE_W + 2;
   localparam logic [SUM_W-1:0] CENTRE = SUM_W'(1) << (CODE_W-1);
   localparam logic [CODE_W-1:0] TOP   = {CODE_W{1'b1}};

   logic [SUM_W-1:0]  sum;
   logic              below_zero;
   logic              above_top;
   logic [CODE_W-1:0] clamped;

   assign sum        = SUM_W'(s_scaled) + SUM_W'(s_ofs) - CENTRE;
   assign below_zero = sum[SUM_W-1];
   assign above_top  = !sum[SUM_W-1] && sum[CODE_W];

   always_comb begin
      if (below_zero)     clamped = '0;
      else if (above_top) clamped = TOP;
      else                clamped = sum[CODE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
      end else begin
         out_valid <= s_valid;
         if (s_valid) out_code <= clamped;
      end
   end

   AST_NO_LOWERING: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ofs[CODE_W-1]) |=> (out_code >= $past(s_scaled))); // R5
   AST_NO_RAISING: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && !s_ofs[CODE_W-1]) |=> (out_code <= $past(s_scaled))); // R6
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !s_valid |=> (!out_valid && $stable(out_code))); // R10
endmodule

// File: rtl/dac_lincal.sv
module dac_lincal #(
   parameter int CODE_W    = 16,
   parameter int GAIN_W    = 16,
   parameter bit SHIFT_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CODE_W-1:0] cfg_data,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_code,
   output logic              out_valid,
   output logic [CODE_W-1:0] out_code
);
   generate
      if (CODE_W < 4 || CODE_W > 24) begin : g_bad_code_w
         $error("dac_lincal: CODE_W must lie in 4..24");
      end
      if (GAIN_W < 1 || GAIN_W > CODE_W) begin : g_bad_gain_w
         $error("dac_lincal: GAIN_W must lie in 1..CODE_W");
      end
   endgenerate

   logic [GAIN_W-1:0] gain_q;
   logic [CODE_W-1:0] ofs_q;
   logic              s_valid;
   logic [CODE_W-1:0] s_scaled;
   logic [CODE_W-1:0] s_ofs;

   dac_lincal_coef #(.GAIN_W(GAIN_W), .CODE_W(CODE_W)) u_coef (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_data (cfg_data),
      .gain_q   (gain_q),
      .ofs_q    (ofs_q)
   );

   dac_lincal_scale #(.CODE_W(CODE_W), .GAIN_W(GAIN_W), .SHIFT_ADD(SHIFT_ADD)) u_scale (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_code  (in_code),
      .gain     (gain_q),
      .ofs      (ofs_q),
      .s_valid  (s_valid),
      .s_scaled (s_scaled),
      .s_ofs    (s_ofs)
   );

   dac_lincal_shift #(.CODE_W(CODE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_valid   (s_valid),
      .s_scaled  (s_scaled),
      .s_ofs     (s_ofs),
      .out_valid (out_valid),
      .out_code  (out_code)
   );

   AST_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2)); // R7
endmodule

// File: tb/dac_lincal_test.sv
module dac_lincal_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [15:0] cfg_data = '0;
   logic        in_valid = 1'b0;
   logic [15:0] in_code = '0;
   logic        out_valid;
   logic [15:0] out_code;

   dac_lincal uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .in_valid(in_valid), .in_code(in_code),
      .out_valid(out_valid), .out_code(out_code)
   );

   always #10 clk = ~clk;

   typedef struct {
      int     expv;
      longint due;
      string  tag;
   } item_t;

   item_t  q[$];
   longint cyc = 0;
   int     n_cmp = 0;
   int     n_bad = 0;
   int     mm = 16'hFFFF;
   int     cc = 16'h8000;
   int     last_out = 0;
   bit     done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int ref_fn(int code, int m, int c);
      longint p = (longint'(code) * longint'(m + 1)) >>> 16;
      longint s = p + longint'(c) - 32768;
      if (s < 0) s = 0;
      if (s > 65535) s = 65535;
      return int'(s);
   endfunction

   task automatic check(string tag, int act, int expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, expv, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (q.size() == 0 || q[0].due != cyc) begin
               check("R7 unexpected or early out_valid", 1, 0);
            end else begin
               check(q[0].tag, int'(out_code), q[0].expv);
               void'(q.pop_front());
            end
            last_out = int'(out_code);
         end else begin
            if (q.size() != 0 && q[0].due == cyc) begin
               check("R7 missing out_valid", 0, 1);
               void'(q.pop_front());
            end
            check("R10 out_code held while idle", int'(out_code), last_out);
         end
      end
   end

   task automatic step(bit v, int code, bit we, bit sel, int data, string tag);
      @(negedge clk);
      in_valid = v;
      in_code  = 16'(code);
      cfg_we   = we;
      cfg_sel  = sel;
      cfg_data = 16'(data);
      if (v) begin
         item_t it;
         it.expv = ref_fn(code & 16'hFFFF, mm, cc);
         it.due  = cyc + 2;
         it.tag  = tag;
         q.push_back(it);
      end
      if (we) begin
         if (sel) cc = data & 16'hFFFF;
         else     mm = data & 16'hFFFF;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, (i * 40503) & 16'hFFFF, 1'b0, 1'b0, 0, "idle");
   endtask

   task automatic set_coef(int m, int c);
      step(1'b0, 0, 1'b1, 1'b0, m, "cfg");
      step(1'b0, 0, 1'b1, 1'b1, c, "cfg");
   endtask

   task automatic sweep(int lo, int hi, int stride, string tag);
      for (int k = lo; k <= hi; k += stride) step(1'b1, k, 1'b0, 1'b0, 0, tag);
      step(1'b1, hi, 1'b0, 1'b0, 0, tag);
   endtask

   task automatic do_reset(string tag);
      idle(4);
      @(negedge clk);
      rst_n = 1'b0;
      mm = 16'hFFFF;
      cc = 16'h8000;
      @(negedge clk);
      @(negedge clk);
      check({tag, " out_valid in reset"}, int'(out_valid), 0);
      check({tag, " out_code in reset"}, int'(out_code), 0);
      last_out = 0;
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 out_valid after reset", int'(out_valid), 0);
      check("R1 out_code after reset", int'(out_code), 0);
      rst_n = 1'b1;
      idle(2);

      // R2: exhaustive identity sweep with the reset coefficients
      sweep(0, 65535, 1, "R2 identity");
      idle(3);

      // R3 / R4: measured-error style corrections
      set_coef(16'hFFFF - 326, 16'h8000 + 196);
      sweep(0, 65535, 257, "R3 R4 span and offset correction");
      set_coef(16'h7FFF, 16'h8000);
      sweep(0, 65535, 263, "R3 half gain");
      set_coef(16'h0000, 16'h8000);
      sweep(0, 65535, 4099, "R3 minimum gain");
      set_coef(16'h3A5C, 16'h8000);
      sweep(1, 65535, 311, "R3 odd gain");
      set_coef(16'hFFFF, 16'h8000 - 65);
      sweep(0, 65535, 509, "R4 negative offset");

      // R5: high clamp
      set_coef(16'hFFFF, 16'hFFFF);
      sweep(32000, 65535, 97, "R5 clamp high");
      // R6: low clamp
      set_coef(16'hFFFF, 16'h0000);
      sweep(0, 33000, 101, "R6 clamp low");
      set_coef(16'hFFFF, 16'h8000);

      // R7: bubbles in the stream
      for (int k = 0; k < 60; k++) step(k % 3 != 1, k * 1093, 1'b0, 1'b0, 0, "R7 gapped stream");
      idle(3);

      // R8: writes on the same edge as a valid word
      for (int k = 0; k < 20; k++) begin
         step(1'b1, 40000 + k, 1'b1, 1'b0, 16'hFFFF - 200 * k, "R8 gain write boundary");
         step(1'b1, 40000 + k, 1'b0, 1'b0, 0, "R8 gain write boundary");
         step(1'b1, 1000 + 3000 * k, 1'b1, 1'b1, 16'h8000 + 150 * k - 1500, "R8 offset write boundary");
         step(1'b1, 1000 + 3000 * k, 1'b0, 1'b0, 0, "R8 offset write boundary");
      end

      // R10: changing input code while not valid
      idle(20);

      // R9: reset restores defaults
      set_coef(16'h1234, 16'hC000);
      sweep(0, 65535, 8191, "R9 before reset");
      do_reset("R9");
      sweep(0, 65535, 1021, "R9 defaults after reset");

      idle(5);
      check("R7 all words delivered", q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 190000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule